// File: doc/BRIEF.md
# Sensor FIFO Packet Stream Decoder

This block sits behind whatever transport drains an inertial-sensor FIFO. It takes the drained bytes one at a time and cuts them into packets. The first byte of each packet is a header, and its flag bits set both the packet length and which payloads follow. For each complete packet the block gives one result strobe carrying the accelerometer sample, gyroscope sample, temperature byte and timestamp, each of them only when present. It also keeps per-read counters of total, valid-gyroscope and valid-accelerometer packets.

A read begins with a one-cycle `start` pulse. The pulse carries three things: the FIFO byte count reported by the sensor, a requested packet count, and whether both sensors are enabled. The block limits the read to a byte budget. The budget is the requested count times the expected packet size, or the buffer capacity when the requested count is zero, and never more than the FIFO count. Bytes arrive on a valid/ready stream. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. The source must hold `in_data` steady while `in_valid` is high and `in_ready` is low. `in_ready` is high only while a read is in progress and budget remains, so the block never accepts a byte beyond its budget.

A header with bit 7 set means the FIFO is empty. A header with neither sensor flag set is invalid. Either one ends the read. A read ends in three ways: the budget runs out, an empty-FIFO header arrives, or an invalid header arrives. The end is signalled by a one-cycle `done` pulse, and the counters hold their values until the next `start`.

Top module: `fifo_stream_decoder`

## Requirements
- R1: A header with bit 7 set causes a strobe with `pkt_empty`=1, `pkt_len`=0 and all payload outputs and flags zero. It leaves the counters unchanged, ends the read with `done` in the same cycle as the strobe, and no further byte is accepted.
- R2: Header bit 6 marks an accelerometer payload and bit 5 a gyroscope payload. Header bits 3:2 appear on `pkt_tsync`. `pkt_odr` bit 1 copies header bit 1 (accelerometer rate change) and `pkt_odr` bit 0 copies header bit 0 (gyroscope rate change).
- R3: With both sensor flags set, the packet is 16 bytes: header, accel sample (bytes 1-6), gyro sample (bytes 7-12), temperature (byte 13), then the timestamp with its high byte first (bytes 14-15). `pkt_len` is 16.
- R4: With exactly one sensor flag set, the packet is 8 bytes: header, sample (bytes 1-6), temperature (byte 7). The sample appears only on the output of the flagged sensor, the other sample output is zero, `pkt_tstamp` is zero, and `pkt_len` is 8.
- R5: A header that is not marked empty but has neither sensor flag set raises `err` together with `done`. It produces no strobe, and no further byte is accepted.
- R6: A read accepts at most B bytes, where B = min(`fifo_bytes`, L). L = `req_pkts`×16 when `pair_mode`=1, `req_pkts`×8 when `pair_mode`=0, and `CAP_BYTES` when `req_pkts`=0. A packet cut short by the budget produces no strobe and is not counted.
- R7: With B = 0, `done` pulses in the cycle after `start`, no byte is accepted, and all counters read zero.
- R8: `cnt_total` increments once per complete packet. `cnt_gyro` and `cnt_accel` increment only when that payload is present and valid. A sample is six bytes, holding three big-endian signed 16-bit axes, presented as {x,y,z} on 48 bits. It is invalid when all three axes equal 0x8000.
- R9: The result strobe `pkt_valid` is high for exactly the one cycle after the clock edge that accepted the last byte of a packet. `in_ready` is low when no read is running, and `start` has no effect while `busy` is high.
- R10: After reset, `busy`, `done`, `err`, `pkt_valid` and `in_ready` are low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read (ignored while busy) |
| fifo_bytes | input | CNT_W | FIFO byte count for this read |
| req_pkts | input | REQ_W | Requested packet count, 0 = buffer capacity |
| pair_mode | input | 1 | Both sensors enabled (expected packet size 16, else 8) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| err | output | 1 | Invalid header seen in the last read |
| pkt_valid | output | 1 | One-cycle packet result strobe |
| pkt_empty | output | 1 | Strobe reports an empty-FIFO header |
| pkt_len | output | 5 | Packet length in bytes |
| pkt_accel_en | output | 1 | Accelerometer payload present |
| pkt_gyro_en | output | 1 | Gyroscope payload present |
| pkt_odr | output | 2 | Rate-change mask: bit 1 accel, bit 0 gyro |
| pkt_tsync | output | 2 | Timestamp/sync field from header bits 3:2 |
| pkt_accel | output | 48 | Accelerometer sample {x,y,z} |
| pkt_gyro | output | 48 | Gyroscope sample {x,y,z} |
| pkt_temp | output | 8 | Temperature byte |
| pkt_tstamp | output | 16 | Packet timestamp |
| cnt_total | output | PKT_CNT_W | Packets parsed in this read |
| cnt_gyro | output | PKT_CNT_W | Packets with valid gyroscope data |
| cnt_accel | output | PKT_CNT_W | Packets with valid accelerometer data |

## Verification
The assertions check, on every cycle, the invariants that hold in every packet:

- each strobe directly follows an accepted byte;
- the reported length matches the presence flags;
- a single-sensor packet carries no timestamp;
- an empty-FIFO strobe or an error coincides with the end of the read;
- the per-sensor counters never pass the total, which steps by one per packet.

Some behaviour only the bench scenarios can show. This covers the exact byte placement and big-endian assembly of samples and timestamps, and the all-0x8000 invalid-sample rule. It also covers where the budget clamps the read under each limit source, dropping of a truncated packet, early stop at empty or invalid headers, and correct results under stalled input.

// File: rtl/fifo_stream_pkg.sv
package fifo_stream_pkg;
  localparam int PAIR_LEN     = 16;
  localparam int SOLO_LEN     = 8;
  localparam int SAMPLE_BYTES = 6;
  localparam int SAMPLE_W     = 8 * SAMPLE_BYTES;

  typedef struct packed {
    logic       empty;
    logic       bad;
    logic       acc;
    logic       gyr;
    logic [1:0] odr;
    logic [1:0] tsync;
    logic [4:0] len;
  } hdr_t;

  // A sample with every axis at the most negative code carries no data
  function automatic logic sample_valid(input logic [SAMPLE_W-1:0] s);
    return s != {3{16'h8000}};
  endfunction
endpackage

// File: rtl/fifo_hdr_decode.sv
module fifo_hdr_decode
  import fifo_stream_pkg::*;
(
  input  logic [7:0] hdr_byte,
  output hdr_t       info
);
  always_comb begin
    info = '0;
    info.empty = hdr_byte[7];
    if (!hdr_byte[7]) begin
      info.acc   = hdr_byte[6];
      info.gyr   = hdr_byte[5];
      info.tsync = hdr_byte[3:2];
      info.odr   = {hdr_byte[1], hdr_byte[0]};
      info.bad   = !(hdr_byte[6] || hdr_byte[5]);
      if (hdr_byte[6] && hdr_byte[5])      info.len = 5'(PAIR_LEN);
      else if (hdr_byte[6] || hdr_byte[5]) info.len = 5'(SOLO_LEN);
    end
  end
endmodule

// File: rtl/fifo_read_budget.sv
module fifo_read_budget
  import fifo_stream_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int REQ_W     = 8,
  parameter int CAP_BYTES = 2048
) (
  input  logic [CNT_W-1:0] fifo_bytes,
  input  logic [REQ_W-1:0] req_pkts,
  input  logic             pair_mode,
  output logic [CNT_W-1:0] budget
);
  localparam int PROD_W = REQ_W + $clog2(PAIR_LEN);
  localparam int WIDE   = ((CNT_W > PROD_W) ? CNT_W : PROD_W) + 1;
  localparam int SH_PAIR = $clog2(PAIR_LEN);
  localparam int SH_SOLO = $clog2(SOLO_LEN);

  logic [WIDE-1:0] limit;

  always_comb begin
    if (req_pkts == '0)
      limit = WIDE'(CAP_BYTES);
    else if (pair_mode)
      limit = WIDE'(req_pkts) << SH_PAIR;
    else
      limit = WIDE'(req_pkts) << SH_SOLO;
    budget = (WIDE'(fifo_bytes) > limit) ? CNT_W'(limit) : fifo_bytes;
  end
endmodule

// File: rtl/fifo_pkt_store.sv
module fifo_pkt_store #(
  parameter int SLOTS = 14,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_byte,
  output logic [8*SLOTS-1:0] bytes_flat
);
  // slot g holds packet byte g (byte 0, the header, is kept elsewhere)
  for (genvar g = 1; g <= SLOTS; g++) begin : g_slot
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               r <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))    r <= wr_byte;
    end
    assign bytes_flat[(g-1)*8 +: 8] = r;
  end
endmodule

// File: rtl/fifo_stream_decoder.sv
module fifo_stream_decoder
  import fifo_stream_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int REQ_W     = 8,
  parameter int CAP_BYTES = 2048,
  parameter int PKT_CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     fifo_bytes,
  input  logic [REQ_W-1:0]     req_pkts,
  input  logic                 pair_mode,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 pkt_valid,
  output logic                 pkt_empty,
  output logic [4:0]           pkt_len,
  output logic                 pkt_accel_en,
  output logic                 pkt_gyro_en,
  output logic [1:0]           pkt_odr,
  output logic [1:0]           pkt_tsync,
  output logic [47:0]          pkt_accel,
  output logic [47:0]          pkt_gyro,
  output logic [7:0]           pkt_temp,
  output logic [15:0]          pkt_tstamp,
  output logic [PKT_CNT_W-1:0] cnt_total,
  output logic [PKT_CNT_W-1:0] cnt_gyro,
  output logic [PKT_CNT_W-1:0] cnt_accel
);
  localparam int IDX_W = $clog2(PAIR_LEN);
  localparam int SLOTS = PAIR_LEN - 2;

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t             state;
  logic [CNT_W-1:0]   remain, budget;
  logic [IDX_W-1:0]   idx;
  hdr_t               hdr_now, hdr_q;
  logic [8*SLOTS-1:0] pb;
  logic               accept, last_budget, last_byte, pair;
  logic [47:0]        s_first, s_second, asm_acc, asm_gyr;
  logic [7:0]         asm_temp;
  logic [15:0]        asm_ts;

  function automatic logic [47:0] pick6(input logic [8*SLOTS-1:0] f, input int first);
    logic [47:0] r;
    for (int i = 0; i < SAMPLE_BYTES; i++)
      r[47-8*i -: 8] = f[(first+i-1)*8 +: 8];
    return r;
  endfunction

  fifo_hdr_decode u_hdr (.hdr_byte(in_data), .info(hdr_now));

  fifo_read_budget #(.CNT_W(CNT_W), .REQ_W(REQ_W), .CAP_BYTES(CAP_BYTES)) u_budget (
    .fifo_bytes(fifo_bytes), .req_pkts(req_pkts), .pair_mode(pair_mode), .budget(budget)
  );

  fifo_pkt_store #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && idx != '0),
    .wr_idx(idx), .wr_byte(in_data), .bytes_flat(pb)
  );

  assign in_ready    = (state == S_RUN);
  assign busy        = (state == S_RUN);
  assign accept      = in_valid && in_ready;
  assign last_budget = (remain == CNT_W'(1));
  assign last_byte   = (idx == IDX_W'(hdr_q.len - 5'd1));
  assign pair        = hdr_q.acc && hdr_q.gyr;

  always_comb begin
    s_first  = pick6(pb, 1);
    s_second = pick6(pb, 1 + SAMPLE_BYTES);
    asm_acc  = hdr_q.acc ? s_first : '0;
    asm_gyr  = pair ? s_second : (hdr_q.gyr ? s_first : '0);
    asm_temp = pair ? pb[(2*SAMPLE_BYTES)*8 +: 8] : in_data;
    asm_ts   = pair ? {pb[(2*SAMPLE_BYTES+1)*8 +: 8], in_data} : 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; remain <= '0; idx <= '0; hdr_q <= '0;
      done <= 1'b0; err <= 1'b0; pkt_valid <= 1'b0; pkt_empty <= 1'b0;
      pkt_len <= '0; pkt_accel_en <= 1'b0; pkt_gyro_en <= 1'b0;
      pkt_odr <= '0; pkt_tsync <= '0; pkt_accel <= '0; pkt_gyro <= '0;
      pkt_temp <= '0; pkt_tstamp <= '0;
      cnt_total <= '0; cnt_gyro <= '0; cnt_accel <= '0;
    end else begin
      pkt_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cnt_total <= '0; cnt_gyro <= '0; cnt_accel <= '0;
          err <= 1'b0; idx <= '0; remain <= budget;
          if (budget == '0) done  <= 1'b1;
          else              state <= S_RUN;
        end
        S_RUN: if (accept) begin
          remain <= remain - CNT_W'(1);
          if (idx == '0) begin
            hdr_q <= hdr_now;
            if (hdr_now.empty) begin
              pkt_valid <= 1'b1; pkt_empty <= 1'b1; pkt_len <= '0;
              pkt_accel_en <= 1'b0; pkt_gyro_en <= 1'b0; pkt_odr <= '0;
              pkt_tsync <= '0; pkt_accel <= '0; pkt_gyro <= '0;
              pkt_temp <= '0; pkt_tstamp <= '0;
              done <= 1'b1; state <= S_IDLE;
            end else if (hdr_now.bad) begin
              err <= 1'b1; done <= 1'b1; state <= S_IDLE;
            end else begin
              idx <= IDX_W'(1);
              if (last_budget) begin done <= 1'b1; state <= S_IDLE; end
            end
          end else begin
            if (last_byte) begin
              pkt_valid <= 1'b1; pkt_empty <= 1'b0; pkt_len <= hdr_q.len;
              pkt_accel_en <= hdr_q.acc; pkt_gyro_en <= hdr_q.gyr;
              pkt_odr <= hdr_q.odr; pkt_tsync <= hdr_q.tsync;
              pkt_accel <= asm_acc; pkt_gyro <= asm_gyr;
              pkt_temp <= asm_temp; pkt_tstamp <= asm_ts;
              cnt_total <= cnt_total + 1'b1;
              if (hdr_q.gyr && sample_valid(asm_gyr)) cnt_gyro  <= cnt_gyro + 1'b1;
              if (hdr_q.acc && sample_valid(asm_acc)) cnt_accel <= cnt_accel + 1'b1;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
            if (last_budget) begin done <= 1'b1; state <= S_IDLE; end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  empty_ends_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_empty |-> done && pkt_len == 5'd0 && cnt_total == $past(cnt_total));
  // R3
  len_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_empty |-> pkt_len == ((pkt_accel_en && pkt_gyro_en) ? 5'd16 : 5'd8));
  // R4
  solo_no_tstamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !(pkt_accel_en && pkt_gyro_en) |-> pkt_tstamp == 16'h0000);
  // R5
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done && !pkt_valid);
  // R8
  sensor_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_gyro <= cnt_total && cnt_accel <= cnt_total);
  // R8
  total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_empty |-> cnt_total == $past(cnt_total) + 1'b1);
  // R9
  strobe_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(in_valid && in_ready));
  // R9
  done_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !in_ready);
  // R2
  payload_hdr_sane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && idx != '0 |-> !hdr_q.empty && !hdr_q.bad);
endmodule

// File: tb/fifo_stream_decoder_test.sv
`timescale 1ns/1ps
module fifo_stream_decoder_test;
  localparam int CAP = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, pair_mode, in_valid, in_ready, busy, done, err;
  logic [15:0] fifo_bytes; logic [7:0] req_pkts, in_data;
  logic pkt_valid, pkt_empty, pkt_accel_en, pkt_gyro_en;
  logic [4:0] pkt_len; logic [1:0] pkt_odr, pkt_tsync;
  logic [47:0] pkt_accel, pkt_gyro; logic [7:0] pkt_temp; logic [15:0] pkt_tstamp;
  logic [11:0] cnt_total, cnt_gyro, cnt_accel;

  fifo_stream_decoder #(.CAP_BYTES(CAP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fifo_bytes(fifo_bytes), .req_pkts(req_pkts),
    .pair_mode(pair_mode), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .busy(busy), .done(done), .err(err), .pkt_valid(pkt_valid), .pkt_empty(pkt_empty),
    .pkt_len(pkt_len), .pkt_accel_en(pkt_accel_en), .pkt_gyro_en(pkt_gyro_en),
    .pkt_odr(pkt_odr), .pkt_tsync(pkt_tsync), .pkt_accel(pkt_accel), .pkt_gyro(pkt_gyro),
    .pkt_temp(pkt_temp), .pkt_tstamp(pkt_tstamp), .cnt_total(cnt_total),
    .cnt_gyro(cnt_gyro), .cnt_accel(cnt_accel)
  );

  // row: hdr[19:12] inv[11] len[10:6] npkt[5:4] total[3] gyro[2] accel[1] err[0]
  localparam logic [19:0] VECS [10] = '{
    {8'h60, 1'b0, 5'd16, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h40, 1'b0, 5'd8,  2'd1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h20, 1'b0, 5'd8,  2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h63, 1'b0, 5'd16, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h42, 1'b0, 5'd8,  2'd1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h60, 1'b1, 5'd16, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h20, 1'b1, 5'd8,  2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h80, 1'b0, 5'd0,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h0C, 1'b0, 5'd0,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h6D, 1'b0, 5'd16, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  int n_chk = 0, n_fail = 0;
  logic [7:0] stream [128]; int slen, ptr;
  int e_n, mon_n;
  logic [4:0] e_len [16], m_len [16];
  logic [2:0] e_flg [16], m_flg [16];
  logic [3:0] e_ctl [16], m_ctl [16];
  logic [47:0] e_acc [16], m_acc [16], e_gyr [16], m_gyr [16];
  logic [7:0] e_tmp [16], m_tmp [16];
  logic [15:0] e_ts [16], m_ts [16];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    stream[slen] = b; slen++;
  endtask

  task automatic push6(input logic [47:0] s);
    for (int i = 0; i < 6; i++) push(s[47-8*i -: 8]);
  endtask

  task automatic add_pkt(input logic [7:0] hdr, input logic [7:0] seed, input bit inv);
    logic [47:0] s1, s2; logic a, g;
    a = hdr[6]; g = hdr[5];
    push(hdr);
    if (hdr[7]) begin
      e_len[e_n] = 0; e_flg[e_n] = 3'b100; e_ctl[e_n] = 0; e_acc[e_n] = 0;
      e_gyr[e_n] = 0; e_tmp[e_n] = 0; e_ts[e_n] = 0; e_n++;
      return;
    end
    if (!a && !g) return;
    s1 = inv ? {3{16'h8000}} : {seed, 8'h11, seed, 8'h22, seed, 8'h33};
    s2 = {~seed, 8'h44, ~seed, 8'h55, ~seed, 8'h66};
    e_flg[e_n] = {1'b0, a, g}; e_ctl[e_n] = {hdr[1:0], hdr[3:2]};
    e_tmp[e_n] = seed ^ 8'hA5;
    push6(s1);
    if (a && g) begin
      push6(s2); push(seed ^ 8'hA5); push(seed); push(8'h5A);
      e_len[e_n] = 16; e_acc[e_n] = s1; e_gyr[e_n] = s2; e_ts[e_n] = {seed, 8'h5A};
    end else begin
      push(seed ^ 8'hA5);
      e_len[e_n] = 8; e_acc[e_n] = a ? s1 : 48'h0; e_gyr[e_n] = g ? s1 : 48'h0; e_ts[e_n] = 0;
    end
    e_n++;
  endtask

  task automatic run_read(input int fb, input int rq, input bit both, input bit gap, input bit poke);
    bit seen = 0; bit hs;
    mon_n = 0; ptr = 0;
    @(negedge clk);
    fifo_bytes = 16'(fb); req_pkts = 8'(rq); pair_mode = both; start = 1'b1;
    @(negedge clk);
    start = poke;
    for (int c = 0; c < 4000 && !seen; c++) begin
      if (pkt_valid && mon_n < 16) begin
        m_len[mon_n] = pkt_len; m_flg[mon_n] = {pkt_empty, pkt_accel_en, pkt_gyro_en};
        m_ctl[mon_n] = {pkt_odr, pkt_tsync}; m_acc[mon_n] = pkt_accel; m_gyr[mon_n] = pkt_gyro;
        m_tmp[mon_n] = pkt_temp; m_ts[mon_n] = pkt_tstamp; mon_n++;
      end
      if (done) seen = 1;
      else begin
        in_valid = (ptr < slen) && !(gap && (c % 3 == 1));
        in_data = stream[ptr % 128];
        hs = in_valid && in_ready;
        @(posedge clk);
        if (hs) ptr++;
        @(negedge clk);
      end
    end
    start = 1'b0; in_valid = 1'b0;
    if (!seen) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual=no done expected=done");
    end
  endtask

  task automatic cmp_pkts();
    for (int k = 0; k < mon_n && k < 16; k++) begin
      chk("R1 R2 presence/empty flags", 64'(m_flg[k]), 64'(e_flg[k]));
      chk("R2 odr mask and tsync field", 64'(m_ctl[k]), 64'(e_ctl[k]));
      chk("R3 R4 packet length", 64'(m_len[k]), 64'(e_len[k]));
      chk("R3 R4 accel sample", 64'(m_acc[k]), 64'(e_acc[k]));
      chk("R3 R4 gyro sample", 64'(m_gyr[k]), 64'(e_gyr[k]));
      chk("R3 R4 temperature", 64'(m_tmp[k]), 64'(e_tmp[k]));
      chk("R3 R4 timestamp", 64'(m_ts[k]), 64'(e_ts[k]));
    end
  endtask

  task automatic chk_counts(input string tag, input int np, input int t, input int g,
                            input int a, input int p, input bit e);
    chk({tag, " packet strobes"}, 64'(mon_n), 64'(np));
    chk("R8 total count", 64'(cnt_total), 64'(t));
    chk("R8 gyro count", 64'(cnt_gyro), 64'(g));
    chk("R8 accel count", 64'(cnt_accel), 64'(a));
    chk({tag, " bytes accepted"}, 64'(ptr), 64'(p));
    chk({tag, " err"}, 64'(err), 64'(e));
  endtask

  initial begin
    rst_n = 0; start = 0; fifo_bytes = 0; req_pkts = 0; pair_mode = 0; in_valid = 0; in_data = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy/done/err/strobe/ready", 64'({busy, done, err, pkt_valid, in_ready}), 64'(0));
    chk("R10 counters", 64'({cnt_total, cnt_gyro, cnt_accel}), 64'(0));
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      logic [19:0] v; int fb;
      v = VECS[i]; slen = 0; e_n = 0;
      add_pkt(v[19:12], 8'(i + 1), v[11]);
      fb = (v[10:6] == 0) ? 8 : int'(v[10:6]);
      while (slen < fb) push(8'h55);
      run_read(fb, 0, v[18] & v[17], i[0], 1'b0);
      chk_counts(v[0] ? "R5" : (v[19] ? "R1" : "R3 R4"), int'(v[5:4]), int'(v[3]),
                 int'(v[2]), int'(v[1]), (v[10:6] == 0) ? 1 : int'(v[10:6]), v[0]);
      cmp_pkts();
    end

    // R7 zero FIFO count: nothing taken, counters cleared
    slen = 0; e_n = 0; add_pkt(8'h40, 8'h70, 1'b0);
    run_read(0, 0, 1'b0, 1'b0, 1'b0);
    chk_counts("R7", 0, 0, 0, 0, 0, 1'b0);

    // R6 clamp by requested count, single-sensor size
    slen = 0; e_n = 0;
    for (int k = 0; k < 3; k++) add_pkt(8'h40, 8'(8'h20 + k), 1'b0);
    run_read(24, 2, 1'b0, 1'b0, 1'b0);
    chk_counts("R6 req*8", 2, 2, 0, 2, 16, 1'b0); cmp_pkts();

    // R6 clamp by requested count, paired size
    slen = 0; e_n = 0;
    for (int k = 0; k < 2; k++) add_pkt(8'h60, 8'(8'h30 + k), 1'b0);
    run_read(32, 1, 1'b1, 1'b0, 1'b0);
    chk_counts("R6 req*16", 1, 1, 1, 1, 16, 1'b0); cmp_pkts();

    // R6 clamp by capacity when request is zero
    slen = 0; e_n = 0;
    for (int k = 0; k < 6; k++) add_pkt(8'h20, 8'(8'h40 + k), 1'b0);
    run_read(48, 0, 1'b0, 1'b0, 1'b0);
    chk_counts("R6 capacity", 4, 4, 4, 0, 32, 1'b0); cmp_pkts();

    // R6 truncated packet dropped
    slen = 0; e_n = 0; add_pkt(8'h60, 8'h50, 1'b0);
    run_read(12, 0, 1'b1, 1'b0, 1'b0);
    chk_counts("R6 truncation", 0, 0, 0, 0, 12, 1'b0);
    chk("R9 ready low when idle", 64'(in_ready), 64'(0));

    // R9 mixed packets, stalled input, start held high while busy
    slen = 0; e_n = 0;
    add_pkt(8'h60, 8'h61, 1'b0); add_pkt(8'h41, 8'h62, 1'b1); add_pkt(8'h20, 8'h63, 1'b0);
    run_read(32, 0, 1'b0, 1'b1, 1'b1);
    chk_counts("R9 stalls/start ignored", 3, 3, 2, 1, 32, 1'b0); cmp_pkts();

    // R1 empty header after a good packet stops parsing
    slen = 0; e_n = 0; add_pkt(8'h40, 8'h71, 1'b0); add_pkt(8'h80, 8'h00, 1'b0);
    while (slen < 20) push(8'h60);
    run_read(20, 0, 1'b0, 1'b0, 1'b0);
    chk_counts("R1 stop", 2, 1, 0, 1, 9, 1'b0); cmp_pkts();

    // R5 invalid header after a good packet
    slen = 0; e_n = 0; add_pkt(8'h20, 8'h72, 1'b0); push(8'h01);
    while (slen < 20) push(8'h40);
    run_read(20, 0, 1'b0, 1'b0, 1'b0);
    chk_counts("R5 stop", 1, 1, 1, 0, 9, 1'b1); cmp_pkts();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule